// File: doc/BRIEF.md
# Period-Tracking Frequency Multiplier

This block raises the frequency of a very slow input waveform, in the range of about half a hertz to five hertz, by a fixed factor of ten or a hundred. The input passes through a synchronizer. Each rising edge of the input marks the start of a new input cycle.

Between two accepted edges, a period meter counts pulses of a slow reference tick. The finished count becomes the modulus of a divider. That divider counts a much faster tick, and a toggle flop at its output produces a square wave.

The output frequency is the input frequency times F/(2R). Here R is the reference tick rate and F is the rate of the selected fast tick. The two fast-tick enables are therefore chosen as 20R and 200R. The modulus is measured again on every input cycle, so the output follows the input across its whole ten-to-one range with no retuning.

All timing comes from one-cycle clock-enable pulses on a single system clock.

Top module: `freq_mult`

## Requirements
- R1: The raw input is sampled through a two-flop synchronizer. Each rising edge yields exactly one measurement event. The period outputs reflect that event by the fourth clock edge after the input rises.
- R2: On an accepted edge, `period_count` takes the number of `ref_tick` pulses seen since the previous accepted edge, and `period_valid` is set. `period_count` changes only in response to an edge.
- R3: The running period count stops at its all-ones value (2^CNT_W−1). While it is held there, `period_valid` is 0. The next edge is then rejected and restarts the measurement from zero.
- R4: An edge that arrives when fewer than MIN_TICKS reference ticks have been counted is ignored. `period_valid` goes to 0 and the running count keeps accumulating up to the next edge.
- R5: The first edge after reset only starts a measurement. It leaves `period_valid` at 0.
- R6: Once running, each high phase and each low phase of `mult_out` lasts exactly `period_count` pulses of the selected fast tick.
- R7: `sel_x100` = 1 selects `fast_tick_x100`, and `sel_x100` = 0 selects `fast_tick_x10`, as the tick counted by the divider.
- R8: A new modulus takes effect only when the divider finishes its current half period. A rejected measurement leaves the modulus unchanged.
- R9: `mult_out` stays 0 from reset until the first valid measurement.
- R10: During reset, `mult_out`, `period_valid` and `period_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Raw slow input waveform (asynchronous) |
| ref_tick | input | 1 | One-cycle enable at the reference rate R |
| fast_tick_x10 | input | 1 | One-cycle enable at 20R |
| fast_tick_x100 | input | 1 | One-cycle enable at 200R |
| sel_x100 | input | 1 | 1: multiply by 100, 0: multiply by 10 |
| mult_out | output | 1 | Multiplied square wave |
| period_count | output | CNT_W | Latest accepted period in reference ticks |
| period_valid | output | 1 | Latest edge produced an accepted period |

## Verification
The synchronizer and the edge stage together delay a rising input by three clock edges before the period registers update. The driver therefore queues an expected result for each edge. The monitor pops that result five falling edges after the input rises, which is safely past the update and far ahead of the next edge.

The bench places input edges midway between reference ticks. Each input period of n ticks then yields a count of exactly n.

Output half periods are timed from one toggle to the next in whole clocks. The first interval after any change of select is skipped. During a change of modulus, every interval must equal either the old length or the new length.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic {
        MUL_X10  = 1'b0,
        MUL_X100 = 1'b1
    } mul_sel_e;

    typedef enum logic [1:0] {
        EDGE_ARM    = 2'd0,
        EDGE_SAT    = 2'd1,
        EDGE_SHORT  = 2'd2,
        EDGE_ACCEPT = 2'd3
    } edge_kind_e;

    function automatic logic pick_tick(mul_sel_e s, logic t10, logic t100);
        return (s == MUL_X100) ? t100 : t10;
    endfunction

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fm_period_meter.sv
module fm_period_meter
    import fm_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int MIN_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_in,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] count,
    output logic             valid,
    output logic             load
);
    localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_TICKS);

    logic             armed;
    logic [CNT_W-1:0] run_cnt;
    edge_kind_e       kind;

    always_comb begin
        if (!armed)                kind = EDGE_ARM;
        else if (run_cnt == SAT_VAL) kind = EDGE_SAT;
        else if (run_cnt < MIN_VAL)  kind = EDGE_SHORT;
        else                         kind = EDGE_ACCEPT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            run_cnt <= '0;
            count   <= '0;
            valid   <= 1'b0;
            load    <= 1'b0;
        end else begin
            load <= 1'b0;
            if (edge_in) begin
                case (kind)
                    EDGE_ARM: begin
                        armed   <= 1'b1;
                        run_cnt <= '0;
                        valid   <= 1'b0;
                    end
                    EDGE_SAT: begin
                        run_cnt <= '0;
                        valid   <= 1'b0;
                    end
                    EDGE_SHORT: begin
                        valid <= 1'b0;
                        if (ref_tick) run_cnt <= run_cnt + 1'b1;
                    end
                    default: begin
                        count   <= run_cnt;
                        valid   <= 1'b1;
                        load    <= 1'b1;
                        run_cnt <= '0;
                    end
                endcase
            end else begin
                if (ref_tick && run_cnt != SAT_VAL) run_cnt <= run_cnt + 1'b1;
                if (run_cnt == SAT_VAL) valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fm_var_divider.sv
module fm_var_divider #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] new_mod,
    output logic             wave
);
    logic             running;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] div_cnt;
    logic             terminal;

    assign terminal = (div_cnt == mod_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            mod_q   <= '0;
            pend_q  <= '0;
            div_cnt <= '0;
            wave    <= 1'b0;
        end else if (!running) begin
            if (load) begin
                running <= 1'b1;
                mod_q   <= new_mod;
                pend_q  <= new_mod;
                div_cnt <= '0;
            end
        end else begin
            if (load) pend_q <= new_mod;
            if (tick) begin
                if (terminal) begin
                    wave    <= ~wave;
                    div_cnt <= '0;
                    mod_q   <= pend_q;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/freq_mult.sv
module freq_mult
    import fm_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int MIN_TICKS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             ref_tick,
    input  logic             fast_tick_x10,
    input  logic             fast_tick_x100,
    input  logic             sel_x100,
    output logic             mult_out,
    output logic [CNT_W-1:0] period_count,
    output logic             period_valid
);
    logic edge_pulse;
    logic tick_sel;
    logic load;

    assign tick_sel = pick_tick(mul_sel_e'(sel_x100), fast_tick_x10, fast_tick_x100);

    fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sig_in),
        .rise (edge_pulse)
    );

    fm_period_meter #(.CNT_W(CNT_W), .MIN_TICKS(MIN_TICKS)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .edge_in  (edge_pulse),
        .ref_tick (ref_tick),
        .count    (period_count),
        .valid    (period_valid),
        .load     (load)
    );

    fm_var_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_sel),
        .load    (load),
        .new_mod (period_count),
        .wave    (mult_out)
    );
endmodule

// File: rtl/freq_mult_chk.sv
module freq_mult_chk #(
    parameter int CNT_W     = 12,
    parameter int MIN_TICKS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             edge_pulse,
    input logic             tick_sel,
    input logic             mult_out,
    input logic [CNT_W-1:0] period_count,
    input logic             period_valid
);
    logic seen_valid;

    always_ff @(posedge clk) begin
        if (rst)               seen_valid <= 1'b0;
        else if (period_valid) seen_valid <= 1'b1;
    end

    // R2: the count moves only in response to a detected edge
    p_count_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_count) |-> $past(edge_pulse));

    // R1: valid rises only as a result of an edge
    p_valid_from_edge_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(period_valid) |-> $past(edge_pulse));

    // R6: output toggles only on a selected fast tick
    p_toggle_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(mult_out) |-> $past(tick_sel));

    // R9: output held low until a valid period has been seen
    p_low_until_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !seen_valid |-> !mult_out);

    // R4: a reported period is never below the minimum
    p_valid_min_r4: assert property (@(posedge clk) disable iff (rst)
        period_valid |-> (period_count >= CNT_W'(MIN_TICKS)));

    // R3: an all-ones count is never reported as valid
    p_no_sat_valid_r3: assert property (@(posedge clk) disable iff (rst)
        period_valid |-> (period_count != {CNT_W{1'b1}}));
endmodule

bind freq_mult freq_mult_chk #(.CNT_W(CNT_W), .MIN_TICKS(MIN_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .edge_pulse   (edge_pulse),
    .tick_sel     (tick_sel),
    .mult_out     (mult_out),
    .period_count (period_count),
    .period_valid (period_valid)
);

// File: tb/freq_mult_tb.sv
`timescale 1ns/1ps
module freq_mult_tb;
    localparam int CNT_W = 8;
    localparam int MINT  = 4;
    localparam int SATV  = 255;
    localparam int P     = 50;   // clocks per reference tick
    localparam int S10   = 10;   // clocks per x10 fast tick

    typedef struct {
        bit    v;
        int    cnt;
        bit    chk_low;
        string tag;
    } item_t;

    logic clk = 0;
    logic rst = 1;
    logic sig_in = 0;
    logic sel_x100 = 0;
    logic ref_tick, f10, f100;
    logic mult_out, period_valid;
    logic [CNT_W-1:0] period_count;

    int refc = 0;
    int fc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit armed = 0;
    int acc = 0;
    item_t q[$];
    event item_ev;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        refc <= (refc == P - 1) ? 0 : refc + 1;
        fc   <= (fc == S10 - 1) ? 0 : fc + 1;
    end
    assign ref_tick = (refc == 0);
    assign f10      = (fc == 0);
    assign f100     = 1'b1;

    freq_mult #(.CNT_W(CNT_W), .MIN_TICKS(MINT)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .sig_in         (sig_in),
        .ref_tick       (ref_tick),
        .fast_tick_x10  (f10),
        .fast_tick_x100 (f100),
        .sel_x100       (sel_x100),
        .mult_out       (mult_out),
        .period_count   (period_count),
        .period_valid   (period_valid)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic push(bit v, int c, bit low, string tag);
        item_t it;
        it.v = v; it.cnt = c; it.chk_low = low; it.tag = tag;
        q.push_back(it);
        ->item_ev;
    endtask

    // expected outcome of an input rising edge, then the period that follows
    task automatic decide(int n);
        if (!armed) begin
            armed = 1; acc = 0;
            push(0, 0, 1, "R5/R9 first edge");
        end else if (acc >= SATV) begin
            acc = 0;
            push(0, 0, 0, "R3 saturated period");
        end else if (acc < MINT) begin
            push(0, 0, 0, "R4 short edge ignored");
        end else begin
            push(1, acc, 0, "R2 period count");
            acc = 0;
        end
        acc = (acc + n > SATV) ? SATV : acc + n;
    endtask

    task automatic gen(int n, int k);
        while (refc != P / 2) @(negedge clk);
        for (int i = 0; i < k; i++) begin
            sig_in = 1;
            decide(n);
            repeat (n * P / 2) @(negedge clk);
            sig_in = 0;
            repeat (n * P - n * P / 2) @(negedge clk);
        end
    endtask

    task automatic measure(int nint, int exp_old, int exp_new, string tag);
        logic last;
        int len;
        last = mult_out;
        while (mult_out == last) @(negedge clk);
        for (int i = 0; i < nint; i++) begin
            last = mult_out;
            len = 0;
            while (mult_out == last) begin
                @(negedge clk);
                len++;
            end
            if (i == nint - 1) check(len == exp_new, tag, len, exp_new);
            else check(len == exp_old || len == exp_new, tag, len, exp_new);
        end
    endtask

    // scoreboard monitor: result due by the 4th edge, sampled at the 5th falling edge
    initial begin
        forever begin
            item_t it;
            @(item_ev);
            repeat (5) @(negedge clk);
            it = q.pop_front();
            check(period_valid == it.v, {it.tag, " valid (R1)"}, int'(period_valid), int'(it.v));
            if (it.v) check(period_count == CNT_W'(it.cnt), it.tag, int'(period_count), it.cnt);
            if (it.chk_low) check(mult_out == 1'b0, "R9 output low", int'(mult_out), 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_report();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(mult_out == 0, "R10 mult_out", int'(mult_out), 0);
        check(period_valid == 0, "R10 valid", int'(period_valid), 0);
        check(period_count == 0, "R10 count", int'(period_count), 0);
        rst = 0;
        @(negedge clk);

        gen(20, 4);                            // R5, R9, R2
        fork
            gen(20, 3);
            measure(4, 20 * S10, 20 * S10, "R6 x10 half period");
        join
        sel_x100 = 1;
        fork
            gen(20, 2);
            measure(4, 20, 20, "R7 x100 half period");
        join
        sel_x100 = 0;
        fork
            gen(10, 4);
            measure(8, 20 * S10, 10 * S10, "R8 modulus switch");
        join
        gen(10, 1);
        gen(2, 1);                             // R4: accumulates into 12
        gen(10, 2);
        gen(300, 1);                           // R3: saturates
        gen(20, 2);
        repeat (10) @(negedge clk);
        finish_report();
    end
endmodule